// File: doc/BRIEF.md
# Palette Lookup and Per-Pixel Overlay Mixer

This block places an on-screen overlay over a byte-serial 4:2:2 video stream. Each overlay pixel arrives as a palette index. A host-loaded palette turns the index into a Y/Cb/Cr color, and each palette entry also holds a single keep-overlay flag. For each sample the block sends out either a component of the overlay color or the incoming video sample unchanged, and it does so at a fixed two-cycle latency. The output goes straight to an output encoder.

Video samples arrive one per clock. A marker input separates active picture samples from blanking and timing-reference samples. Within each active run the block counts component slots in the order Cb, Y0, Cr, Y1. An overlay pixel covers two slots. The index is taken on the first slot of each pixel, which is a chroma slot. Both chroma components of the pair come from the even pixel's entry, so Cb and Cr always match across the pair.

The palette is written through a separate port: an address, a 24-bit color and an overlay flag, qualified by a write strobe. The palette has no reset, so it must be loaded before use.

Top module: `osd_clut_mixer`

## Requirements
- R1: When `tbl_wr_en` is high at a clock edge, `{tbl_wr_alpha, tbl_wr_color}` is stored at `tbl_wr_addr`. Color packing is Y in bits 23:16, Cb in 15:8 and Cr in 7:0. Every sample presented after that edge looks up the new contents.
- R2: `vid_out` and `vid_out_active` carry the result for an input sample two clock cycles after that sample is captured.
- R3: The first sample with `vid_in_active` high after a low sample is slot Cb. Slots then cycle Cb, Y0, Cr, Y1, and the count restarts at every new active run.
- R4: In an active slot whose pixel has a clear flag in its entry, `vid_out` equals the delayed `vid_in`.
- R5: In an active slot whose pixel is overlaid, the output is the overlay component. Cb and Y0 come from the Cb and Y of the even pixel's entry. Cr comes from the Cr of the even pixel's entry. Y1 comes from the Y of the odd pixel's entry.
- R6: While `vid_in_active` is low, the sample passes through unchanged and `vid_out_active` is low, whatever the index, valid flag or palette contents.
- R7: If `pix_valid` is low on a pixel's index slot (Cb or Cr), that pixel is transparent for both of its slots.
- R8: The even pixel's flag decides Cb and Y0, and the odd pixel's flag decides Cr and Y1. This holds even when only the odd pixel is overlaid, in which case Cr still uses the even pixel's chroma.
- R9: `pix_idx` and `pix_valid` presented on Y0 and Y1 slots have no effect on the output.
- R10: During reset, `vid_out` and `vid_out_active` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Palette write strobe |
| tbl_wr_addr | input | 8 | Palette entry to write |
| tbl_wr_color | input | 24 | Entry color {Y, Cb, Cr} |
| tbl_wr_alpha | input | 1 | Entry overlay flag (1 = overlay) |
| pix_valid | input | 1 | Overlay index valid on this slot |
| pix_idx | input | 8 | Overlay palette index |
| vid_in | input | 8 | Incoming 4:2:2 video sample |
| vid_in_active | input | 1 | High on active-picture samples |
| vid_out | output | 8 | Mixed 4:2:2 video sample |
| vid_out_active | output | 1 | Delayed active-picture marker |

## Verification
A slot counter that is off by one shows up within one pixel pair as luma values in chroma slots, or as Cr taken from the odd entry. Either error is visible at the third output sample of an active run. A stale even-pixel hold register shows up at the very next Y0 or Cr slot as a component that belongs to a different entry. A misaligned video delay shows up as a pass-through sample that equals a neighbouring input, two cycles after the affected input. Blanking corruption is visible on the first blanking sample that follows an overlaid pixel.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

  typedef enum logic [1:0] {
    SLOT_CB = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_CR = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_e;

  function automatic slot_e slot_next(input slot_e s);
    return slot_e'(s + 2'd1);
  endfunction

  function automatic logic slot_takes_index(input slot_e s);
    return (s == SLOT_CB) || (s == SLOT_CR);
  endfunction

endpackage

// File: rtl/osd_clut_ram.sv
module osd_clut_ram #(
  parameter int AW = 8,
  parameter int DW = 25
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/osd_slot_track.sv
module osd_slot_track
  import osd_mix_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  output slot_e slot
);
  slot_e cnt;

  assign slot = active ? cnt : SLOT_CB;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= SLOT_CB;
    else if (active) cnt <= slot_next(slot);
    else             cnt <= SLOT_CB;
  end
endmodule

// File: rtl/osd_overlay_select.sv
module osd_overlay_select
  import osd_mix_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s1_active,
  input  slot_e           s1_slot,
  input  logic            s1_valid,
  input  logic [CW-1:0]   s1_data,
  input  logic [3*CW-1:0] ent_color,
  input  logic            ent_alpha,
  output logic [CW-1:0]   out_data,
  output logic            out_active,
  output logic            out_ovl
);
  function automatic logic [CW-1:0] y_of(input logic [3*CW-1:0] c);
    return c[3*CW-1:2*CW];
  endfunction
  function automatic logic [CW-1:0] cb_of(input logic [3*CW-1:0] c);
    return c[2*CW-1:CW];
  endfunction
  function automatic logic [CW-1:0] cr_of(input logic [3*CW-1:0] c);
    return c[CW-1:0];
  endfunction

  logic [3*CW-1:0] even_col;
  logic            even_key;
  logic [CW-1:0]   odd_y;
  logic            odd_key;

  logic            cur_key;
  logic [CW-1:0]   pick;
  logic            use_ovl;

  assign cur_key = s1_valid & ent_alpha;

  always_comb begin
    unique case (s1_slot)
      SLOT_CB: begin pick = cb_of(ent_color); use_ovl = cur_key;  end
      SLOT_Y0: begin pick = y_of(even_col);   use_ovl = even_key; end
      SLOT_CR: begin pick = cr_of(even_col);  use_ovl = cur_key;  end
      default: begin pick = odd_y;            use_ovl = odd_key;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      even_col <= '0;
      even_key <= 1'b0;
      odd_y    <= '0;
      odd_key  <= 1'b0;
    end else if (s1_active) begin
      if (s1_slot == SLOT_CB) begin
        even_col <= ent_color;
        even_key <= cur_key;
      end
      if (s1_slot == SLOT_CR) begin
        odd_y   <= y_of(ent_color);
        odd_key <= cur_key;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data   <= '0;
      out_active <= 1'b0;
      out_ovl    <= 1'b0;
    end else begin
      out_active <= s1_active;
      out_ovl    <= s1_active & use_ovl;
      out_data   <= (s1_active & use_ovl) ? pick : s1_data;
    end
  end
endmodule

// File: rtl/osd_clut_mixer.sv
module osd_clut_mixer
  import osd_mix_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_wr_en,
  input  logic [AW-1:0]   tbl_wr_addr,
  input  logic [3*CW-1:0] tbl_wr_color,
  input  logic            tbl_wr_alpha,
  input  logic            pix_valid,
  input  logic [AW-1:0]   pix_idx,
  input  logic [CW-1:0]   vid_in,
  input  logic            vid_in_active,
  output logic [CW-1:0]   vid_out,
  output logic            vid_out_active
);
  localparam int EW = 3 * CW + 1;

  slot_e           in_slot;
  logic            s1_active;
  slot_e           s1_slot;
  logic            s1_valid;
  logic [CW-1:0]   s1_data;
  logic [EW-1:0]   ent;
  logic            out_ovl;

  osd_slot_track u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (vid_in_active),
    .slot   (in_slot)
  );

  osd_clut_ram #(.AW(AW), .DW(EW)) u_ram (
    .clk   (clk),
    .we    (tbl_wr_en),
    .waddr (tbl_wr_addr),
    .wdata ({tbl_wr_alpha, tbl_wr_color}),
    .raddr (pix_idx),
    .rdata (ent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_active <= 1'b0;
      s1_slot   <= SLOT_CB;
      s1_valid  <= 1'b0;
      s1_data   <= '0;
    end else begin
      s1_active <= vid_in_active;
      s1_slot   <= in_slot;
      s1_valid  <= pix_valid & slot_takes_index(in_slot);
      s1_data   <= vid_in;
    end
  end

  osd_overlay_select #(.CW(CW)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_active  (s1_active),
    .s1_slot    (s1_slot),
    .s1_valid   (s1_valid),
    .s1_data    (s1_data),
    .ent_color  (ent[3*CW-1:0]),
    .ent_alpha  (ent[3*CW]),
    .out_data   (vid_out),
    .out_active (vid_out_active),
    .out_ovl    (out_ovl)
  );
endmodule

// File: rtl/osd_mix_chk.sv
module osd_mix_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s1_active,
  input logic [1:0]    s1_slot,
  input logic [CW-1:0] s1_data,
  input logic          out_ovl,
  input logic [CW-1:0] vid_out,
  input logic          vid_out_active
);
  assert_blank_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_active |=> (vid_out == $past(s1_data)) && !vid_out_active);

  assert_active_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_active |=> vid_out_active);

  assert_ovl_only_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovl |-> vid_out_active);

  assert_clear_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_active |=> (out_ovl || vid_out == $past(s1_data)));

  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_active && $past(s1_active)) |-> s1_slot == 2'($past(s1_slot) + 2'd1));

  assert_slot_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s1_active) |-> s1_slot == 2'd0);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_out_R10: assert (!vid_out_active || $isunknown(vid_out_active));
    end
  end
endmodule

bind osd_clut_mixer osd_mix_chk #(.CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .s1_active      (s1_active),
  .s1_slot        (s1_slot),
  .s1_data        (s1_data),
  .out_ovl        (out_ovl),
  .vid_out        (vid_out),
  .vid_out_active (vid_out_active)
);

// File: tb/sim_osd_clut_mixer.sv
`timescale 1ns/1ps
module sim_osd_clut_mixer;
  localparam int AW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            tbl_wr_en;
  logic [AW-1:0]   tbl_wr_addr;
  logic [3*CW-1:0] tbl_wr_color;
  logic            tbl_wr_alpha;
  logic            pix_valid;
  logic [AW-1:0]   pix_idx;
  logic [CW-1:0]   vid_in;
  logic            vid_in_active;
  logic [CW-1:0]   vid_out;
  logic            vid_out_active;

  osd_clut_mixer #(.AW(AW), .CW(CW)) u0 (.*);

  logic [3*CW:0] tbl [256];
  int total = 0, bad = 0;

  int            m_cnt = 0;
  logic [3*CW:0] m_even = '0;
  logic [CW-1:0] m_oddy = '0;
  logic          m_ek = 1'b0, m_ok = 1'b0;

  logic [CW-1:0] e1_d, e2_d;
  logic          e1_a, e2_a, e1_v = 1'b0, e2_v = 1'b0;
  string         e1_t, e2_t;

  function automatic logic [CW-1:0] comp(input logic [3*CW:0] e, input int which);
    return e[CW*which +: CW];
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic act, input logic v, input logic [AW-1:0] ix,
                      input logic [CW-1:0] d, input string tag);
    logic [CW-1:0] exp, pk;
    logic ov;
    @(negedge clk);
    if (e2_v) begin
      check(e2_t, vid_out, e2_d);
      check({"R2 marker ", e2_t}, CW'(vid_out_active), CW'(e2_a));
    end
    if (!act) begin
      exp = d; m_cnt = 0;
    end else begin
      case (m_cnt % 4)
        0: begin m_even = tbl[ix]; m_ek = v & tbl[ix][3*CW]; ov = m_ek; pk = comp(m_even, 1); end
        1: begin ov = m_ek; pk = comp(m_even, 2); end
        2: begin m_oddy = comp(tbl[ix], 2); m_ok = v & tbl[ix][3*CW]; ov = m_ok; pk = comp(m_even, 0); end
        default: begin ov = m_ok; pk = m_oddy; end
      endcase
      exp = ov ? pk : d;
      m_cnt++;
    end
    e2_d = e1_d; e2_a = e1_a; e2_v = e1_v; e2_t = e1_t;
    e1_d = exp;  e1_a = act;  e1_v = 1'b1; e1_t = tag;
    vid_in_active = act; pix_valid = v; pix_idx = ix; vid_in = d;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3*CW-1:0] c, input logic al);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_color = c; tbl_wr_alpha = al;
    tbl[a] = {al, c};
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_color = '0; tbl_wr_alpha = 1'b0;
    pix_valid = 1'b1; pix_idx = 8'h06; vid_in = 8'hA5; vid_in_active = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 reset data", vid_out, '0);
    check("R10 reset marker", CW'(vid_out_active), '0);
    vid_in = '0;
    rst_n = 1'b1;

    for (int i = 0; i < 256; i++) wr(AW'(i), 24'($urandom), 1'($urandom));
    wr(8'h05, 24'h515253, 1'b0);
    wr(8'h06, 24'h616263, 1'b1);
    wr(8'h07, 24'h717273, 1'b1);
    step(1'b0, 1'b0, '0, 8'h10, "R6 idle");

    // R4: overlay flag clear passes video
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 8'h05, 8'(8'h20 + i), "R4 clear flag");
    step(1'b0, 1'b0, '0, 8'h10, "R6 gap");
    // R5: both pixels overlaid, Cr from even entry, Y1 from odd entry
    step(1'b1, 1'b1, 8'h06, 8'h30, "R5 Cb even");
    step(1'b1, 1'b1, 8'h05, 8'h31, "R5 Y0 even");
    step(1'b1, 1'b1, 8'h07, 8'h32, "R5 Cr even chroma");
    step(1'b1, 1'b0, 8'h05, 8'h33, "R5 Y1 odd");
    // R8: even clear, odd overlaid
    step(1'b1, 1'b1, 8'h05, 8'h34, "R8 Cb pass");
    step(1'b1, 1'b1, 8'h06, 8'h35, "R8 Y0 pass");
    step(1'b1, 1'b1, 8'h07, 8'h36, "R8 Cr uses even chroma");
    step(1'b1, 1'b1, 8'h06, 8'h37, "R8 Y1 odd");
    // R7: valid low makes pixel transparent
    step(1'b1, 1'b0, 8'h06, 8'h40, "R7 Cb");
    step(1'b1, 1'b1, 8'h06, 8'h41, "R7 Y0");
    step(1'b1, 1'b0, 8'h07, 8'h42, "R7 Cr");
    step(1'b1, 1'b1, 8'h07, 8'h43, "R7 Y1");
    // R9: Y-slot index and valid are ignored
    step(1'b1, 1'b1, 8'h06, 8'h44, "R9 Cb");
    step(1'b1, 1'b0, 8'h05, 8'h45, "R9 Y0");
    step(1'b1, 1'b1, 8'h05, 8'h46, "R9 Cr");
    step(1'b1, 1'b1, 8'h07, 8'h47, "R9 Y1");
    // R6: timing reference and blanking with overlaid index
    step(1'b0, 1'b1, 8'h06, 8'hFF, "R6 ref");
    step(1'b0, 1'b1, 8'h06, 8'h00, "R6 ref");
    step(1'b0, 1'b1, 8'h06, 8'h00, "R6 ref");
    step(1'b0, 1'b1, 8'h06, 8'hB6, "R6 ref");
    step(1'b0, 1'b1, 8'h06, 8'h80, "R6 blank");
    step(1'b0, 1'b1, 8'h07, 8'h10, "R6 blank");
    // R3: odd-length run, then restart on Cb
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h06, 8'(8'h50 + i), "R3 short run");
    step(1'b0, 1'b1, 8'h06, 8'h10, "R6 gap");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'h07, 8'(8'h58 + i), "R3 restart");
    // R1: rewrite entry, new color seen
    step(1'b0, 1'b0, '0, 8'h10, "R6 gap");
    step(1'b0, 1'b0, '0, 8'h10, "R6 gap");
    wr(8'h06, 24'hC1C2C3, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'h06, 8'(8'h60 + i), "R1 rewritten");

    // random runs
    for (int r = 0; r < 300; r++) begin
      int len = 1 + int'($urandom % 40);
      int gap = 1 + int'($urandom % 6);
      for (int i = 0; i < len; i++)
        step(1'b1, ($urandom % 5) != 0, 8'($urandom), 8'($urandom), "R3 R5 R7 random");
      for (int i = 0; i < gap; i++)
        step(1'b0, 1'($urandom), 8'($urandom), 8'($urandom), "R6 random blank");
    end
    step(1'b0, 1'b0, '0, 8'h10, "R2 flush");
    step(1'b0, 1'b0, '0, 8'h10, "R2 flush");
    step(1'b0, 1'b0, '0, 8'h10, "R2 flush");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule